// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Software Trap

This block sits beside a small 8-bit processor core. It collects requests from a set of maskable hardware sources and keeps each one in a pending flag until the core services it. One global mask bit gates every maskable source. At each instruction boundary the block can start an entry into a service routine. It picks the pending source with the lowest index, raises a one-cycle entry pulse together with that source's 16-bit vector address, and acknowledges the source. The core then pushes its context in the order PC, X, A, CC, and loads PC from the vector.

A software trap instruction enters its own fixed vector and ignores the mask. Every entry sets the mask, so a running routine is not pre-empted. A return strobe clears the mask and asks the core to pop its context. A wake output tells the core when to leave a low-power mode. In Wait mode any request that the mask allows wakes the core. In Halt mode only sources flagged as Halt-capable can wake it.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While the mask bit `imask` is 1, no hardware source is entered; `svc_req` stays 0 at every boundary that carries no trap.
- R2: A request pulse on `src_req[i]` sets a pending flag that is held while masked and is entered at the first boundary after the mask is cleared (by `mask_clr` or `iret`).
- R3: After reset `imask` is 1, `svc_req` and `pop_ctx` are 0, `svc_ack` is 0 and no source is pending.
- R4: Every entry, whether hardware or trap, sets `imask` to 1 in the same cycle that `svc_req` is 1, so further boundaries start no new entry until the mask is cleared.
- R5: A cycle with `iret` high makes `pop_ctx` 1 and `imask` 0 one cycle later; no entry is started in the cycle `iret` is high.
- R6: When several flags are pending, the lowest-index source is entered first; the others remain pending for later entries in ascending index order.
- R7: `trap_req` together with `insn_end` enters the trap whatever `imask` is, and takes precedence over pending hardware sources; `svc_vec` is `VEC_TOP-2`, `svc_ack` is 0, and the hardware flags stay pending.
- R8: Entries occur only in the cycle after `insn_end` is high; `svc_req` is a one-cycle pulse, and nothing is entered without a boundary.
- R9: `wake` is 1 in Wait mode (`lp_mode`=1) when any flag is pending and `imask` is 0. In Halt mode (`lp_mode`=2) it is 1 only if a pending flag whose `halt_cap` bit is 1 exists and `imask` is 0. In run mode (`lp_mode`=0 or 3) it is 0.
- R10: Hardware source i is entered with `svc_vec` = `VEC_TOP-4-2*i` and `svc_ack` one-hot at bit i; its pending flag clears on that acknowledge (reset vector is `VEC_TOP`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | NSRC | Request pulses, one bit per maskable source |
| halt_cap | input | NSRC | Per-source permission to leave Halt mode |
| lp_mode | input | 2 | 0 run, 1 wait, 2 halt, 3 run |
| insn_end | input | 1 | Instruction-boundary strobe |
| trap_req | input | 1 | Trap instruction ends at this boundary |
| iret | input | 1 | Return-from-interrupt strobe |
| mask_clr | input | 1 | Clear-mask instruction strobe |
| imask | output | 1 | Global mask bit |
| svc_req | output | 1 | Entry pulse: push context, jump to svc_vec |
| svc_vec | output | 16 | Vector address of the entry |
| svc_ack | output | NSRC | One-hot acknowledge of the entered source |
| pop_ctx | output | 1 | Pulse: restore context after return |
| wake | output | 1 | Leave the current low-power mode |

## Verification
The assertions assume that the core never asserts `iret` and `trap_req` in the same cycle. They also assume that `trap_req` is only meaningful together with `insn_end`, since both describe the single instruction that just ended. The bench drives each strobe for exactly one cycle from tasks that set one strobe at a time. It never combines a return with a trap. Request pulses are issued apart from boundaries, except where a test aims at a case that arises when several sources request at once.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int          NSRC    = 6,
  parameter logic [15:0] VEC_TOP = 16'hFFFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] halt_cap,
  input  logic [1:0]      lp_mode,
  input  logic            insn_end,
  input  logic            trap_req,
  input  logic            iret,
  input  logic            mask_clr,
  output logic            imask,
  output logic            svc_req,
  output logic [15:0]     svc_vec,
  output logic [NSRC-1:0] svc_ack,
  output logic            pop_ctx,
  output logic            wake
);

  localparam logic [15:0] TRAP_VEC = VEC_TOP - 16'd2;
  localparam logic [15:0] SRC_BASE = VEC_TOP - 16'd4;

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] win_oh;
  logic [15:0]     win_vec;

  always_comb begin
    win_oh  = '0;
    win_vec = SRC_BASE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_oh  = '0;
        win_oh[i] = 1'b1;
        win_vec = SRC_BASE - 16'(2 * i);
      end
    end
  end

  wire take_trap = insn_end && trap_req;
  wire take_hw   = insn_end && !trap_req && !iret && !imask && (|pend);
  wire [NSRC-1:0] clr = take_hw ? win_oh : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      imask   <= 1'b1;
      svc_req <= 1'b0;
      svc_vec <= VEC_TOP;
      svc_ack <= '0;
      pop_ctx <= 1'b0;
    end else begin
      pend    <= (pend & ~clr) | src_req;
      svc_req <= take_trap || take_hw;
      svc_ack <= clr;
      pop_ctx <= iret;
      if (iret || mask_clr) imask <= 1'b0;
      if (take_trap) begin
        imask   <= 1'b1;
        svc_vec <= TRAP_VEC;
      end else if (take_hw) begin
        imask   <= 1'b1;
        svc_vec <= win_vec;
      end
    end
  end

  wire any_en  = !imask && (|pend);
  wire halt_en = !imask && (|(pend & halt_cap));

  assign wake = (lp_mode == 2'd1) ? any_en :
                (lp_mode == 2'd2) ? halt_en : 1'b0;

  a_r4_entry_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> imask);

  a_r10_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(svc_ack));

  a_r1_masked_blocks_hw: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack != '0) |-> !$past(imask));

  a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_ack != '0) |-> (($past(pend) & (svc_ack - 1'b1)) == '0));

  a_r5_return_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ctx |-> (!imask && !svc_req));

  a_r9_halt_wake_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode == 2'd2 && wake) |-> ((pend & halt_cap) != '0));

  a_r8_entry_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(insn_end));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int NSRC = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_req = '0;
  logic [NSRC-1:0] halt_cap = '0;
  logic [1:0]      lp_mode = 2'd0;
  logic            insn_end = 1'b0, trap_req = 1'b0, iret = 1'b0, mask_clr = 1'b0;
  logic            imask, svc_req, pop_ctx, wake;
  logic [15:0]     svc_vec;
  logic [NSRC-1:0] svc_ack;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.NSRC(NSRC), .VEC_TOP(16'hFFFE)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .halt_cap(halt_cap),
    .lp_mode(lp_mode), .insn_end(insn_end), .trap_req(trap_req), .iret(iret),
    .mask_clr(mask_clr), .imask(imask), .svc_req(svc_req), .svc_vec(svc_vec),
    .svc_ack(svc_ack), .pop_ctx(pop_ctx), .wake(wake));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [NSRC-1:0] m);
    src_req = m; @(negedge clk); src_req = '0;
  endtask

  task automatic boundary(input logic trap);
    insn_end = 1'b1; trap_req = trap; @(negedge clk); insn_end = 1'b0; trap_req = 1'b0;
  endtask

  task automatic do_iret;
    iret = 1'b1; @(negedge clk); iret = 1'b0;
  endtask

  task automatic do_clr;
    mask_clr = 1'b1; @(negedge clk); mask_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R3 imask", imask, 1);
    chk("R3 svc_req", svc_req, 0);
    chk("R3 svc_ack", svc_ack, 0);
    chk("R3 pop_ctx", pop_ctx, 0);
    lp_mode = 2'd1; #1;
    chk("R3 nothing pending (wake)", wake, 0);
    lp_mode = 2'd0;
  endtask

  task automatic t_masked_then_cleared;
    req(6'b001000);
    boundary(1'b0);
    chk("R1 masked no entry", svc_req, 0);
    lp_mode = 2'd1; #1;
    chk("R9 wait masked no wake", wake, 0);
    do_clr();
    chk("R9 wait wake", wake, 1);
    lp_mode = 2'd0; #1;
    chk("R9 run no wake", wake, 0);
    repeat (2) @(negedge clk);
    chk("R8 no entry without boundary", svc_req, 0);
    boundary(1'b0);
    chk("R2 entry after clear", svc_req, 1);
    chk("R10 vec src3", svc_vec, 16'hFFF4);
    chk("R10 ack src3", svc_ack, 6'b001000);
    chk("R4 mask set on entry", imask, 1);
    @(negedge clk);
    chk("R8 one-cycle pulse", svc_req, 0);
    do_iret();
    chk("R5 pop_ctx", pop_ctx, 1);
    chk("R5 mask cleared", imask, 0);
    boundary(1'b0);
    chk("R10 flag cleared on ack", svc_req, 0);
  endtask

  task automatic t_priority;
    req(6'b110010);
    boundary(1'b0);
    chk("R6 first src1", svc_ack, 6'b000010);
    chk("R10 vec src1", svc_vec, 16'hFFF8);
    boundary(1'b0);
    chk("R4 no preempt", svc_req, 0);
    do_iret();
    boundary(1'b0);
    chk("R6 second src4", svc_ack, 6'b010000);
    chk("R10 vec src4", svc_vec, 16'hFFF2);
    do_iret();
    boundary(1'b0);
    chk("R6 third src5", svc_ack, 6'b100000);
    chk("R10 vec src5", svc_vec, 16'hFFF0);
    do_iret();
  endtask

  task automatic t_trap;
    req(6'b000100);
    boundary(1'b0);
    chk("R6 src2 entered", svc_ack, 6'b000100);
    req(6'b000001);
    boundary(1'b1);
    chk("R7 trap while masked", svc_req, 1);
    chk("R7 trap vec", svc_vec, 16'hFFFC);
    chk("R7 trap no ack", svc_ack, 0);
    chk("R4 trap sets mask", imask, 1);
    do_iret();
    boundary(1'b1);
    chk("R7 trap over pending hw", svc_vec, 16'hFFFC);
    do_iret();
    boundary(1'b0);
    chk("R7 hw still pending", svc_ack, 6'b000001);
    chk("R10 vec src0", svc_vec, 16'hFFFA);
    do_iret();
  endtask

  task automatic t_halt_wake;
    halt_cap = 6'b000001;
    req(6'b000100);
    lp_mode = 2'd2; #1;
    chk("R9 halt non-capable no wake", wake, 0);
    lp_mode = 2'd1; #1;
    chk("R9 wait any wakes", wake, 1);
    lp_mode = 2'd2;
    req(6'b000001);
    chk("R9 halt capable wakes", wake, 1);
    lp_mode = 2'd3; #1;
    chk("R9 mode3 no wake", wake, 0);
    lp_mode = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_masked_then_cleared();
    t_priority();
    t_trap();
    t_halt_wake();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule